// File: doc/BRIEF.md
# Selectable-Operation Divisor Term Generator

This block produces the divisor term used by each step of a digit-generation loop. It scales a 10-bit loop index by a small unsigned gain, from 0 to 7, using a shift-and-add multiplier. It then combines that product with a 12-bit offset in a 12-bit arithmetic/logic unit built from three 4-bit slices, with look-ahead carries between them. The unit's operation is chosen at run time by six control inputs: a 4-bit function code, a mode bit (arithmetic or bitwise logic) and a carry input. The result can be a plain sum or difference, or any of the other thirty-odd arithmetic and logic combinations of the two operands.

The term is the low 11 bits of the unit's 12-bit result, so it matches the width of the downstream divisor. A term of zero would make the next division invalid, so a zero is replaced by one. With the default build the term is registered, so it appears one clock after its inputs. A parameter turns the register off and gives a purely combinational path.

Top module: `tgen_term`

## Requirements
- R1: While `rst_n` is low, and after reset until the first update, the registered term reads 1.
- R2: Operand A is `idx_i * gain_i` truncated to its low 12 bits, and operand B is `offset_i`. For example, 1023 x 7 = 7161 becomes 3065.
- R3: Arithmetic mode (`logic_mode_i`=0). The result is X + Y + `carry_i`, modulo 4096. X = A | (s0 ? B : 0) | (s1 ? ~B : 0) and Y = A & ((s2 ? ~B : 0) | (s3 ? B : 0)), where s3..s0 are the bits of `fsel_i`. Code 9 with no carry gives A + B.
- R4: Code 6 in arithmetic mode with `carry_i`=1 gives A - B. With gain 2 and offset 1 the term is 2*idx - 1.
- R5: Logic mode (`logic_mode_i`=1) applies a bitwise function chosen by `fsel_i`. The codes are: 0 ~A, 1 ~(A|B), 2 ~A&B, 3 all zeros, 4 ~(A&B), 5 ~B, 6 A^B, 7 A&~B, 8 ~A|B, 9 ~(A^B), 10 B, 11 A&B, 12 all ones, 13 A|~B, 14 A|B, 15 A.
- R6: In logic mode `carry_i` has no effect on the term.
- R7: The term is bits 10..0 of the 12-bit result. Bit 11 is discarded.
- R8: If those 11 bits are all zero, the term is 1 instead.
- R9: Carries pass across the 4-bit slice boundaries. For example, 0x0FF + 1 gives 0x100.
- R10: With the default build the term changes one clock after its inputs and holds between clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_i | input | 10 | Loop index (multiplicand) |
| gain_i | input | 3 | Unsigned gain applied to the index |
| offset_i | input | 12 | Second operand of the operation |
| fsel_i | input | 4 | Function code |
| logic_mode_i | input | 1 | 1 selects bitwise logic, 0 selects arithmetic |
| carry_i | input | 1 | Carry input, active high, used in arithmetic mode |
| term_o | output | 11 | Divisor term, never zero |

## Verification
The assertions check on every cycle that the term is never zero. They also check that addition, subtraction, XOR and the pass-through of the product each produce, one clock later, the value computed from the previous inputs. The bench's scenarios show the behaviour the properties do not capture. These are all 32 mode and code combinations with both carry values, the ripple across slice boundaries, the truncation of the product, the loss of bit 11 together with the zero substitution that follows, the reset value, and the fact that the term does not move before the clock edge.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

    localparam int SLICE_W = 4;

    typedef enum logic {
        MODE_ARITH = 1'b0,
        MODE_LOGIC = 1'b1
    } alu_mode_e;

    typedef struct packed {
        logic gen;
        logic prop;
    } slice_grp_t;

endpackage

// File: rtl/tgen_mult.sv
module tgen_mult #(
    parameter int IDX_W  = 10,
    parameter int GAIN_W = 3,
    parameter int PROD_W = 12
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [GAIN_W-1:0] gain,
    output logic [PROD_W-1:0] prod
);
    localparam int FULL_W = IDX_W + GAIN_W;

    logic [FULL_W-1:0] part [GAIN_W];
    logic [FULL_W-1:0] acc;

    // One shifted copy of the index per gain bit
    for (genvar k = 0; k < GAIN_W; k++) begin : g_part
        assign part[k] = gain[k] ? (FULL_W'(idx) << k) : '0;
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < GAIN_W; k++) begin
            acc = acc + part[k];
        end
    end

    if (PROD_W >= FULL_W) begin : g_wide
        assign prod = PROD_W'(acc);
    end else begin : g_trunc
        assign prod = acc[PROD_W-1:0];
    end
endmodule

// File: rtl/tgen_slice.sv
module tgen_slice
    import tgen_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   fsel,
    input  alu_mode_e    mode,
    input  logic         c_in,
    output logic [W-1:0] f,
    output slice_grp_t   grp
);
    logic [W-1:0] x_op, y_op, gen_b, prop_b, sum_b, log_b;
    logic [W:0]   cy;

    always_comb begin
        // Arithmetic operands: the function code bits gate B and ~B
        x_op   = a | ({W{fsel[0]}} & b) | ({W{fsel[1]}} & ~b);
        y_op   = a & (({W{fsel[2]}} & ~b) | ({W{fsel[3]}} & b));
        gen_b  = x_op & y_op;
        prop_b = x_op ^ y_op;

        cy[0] = c_in;
        for (int i = 0; i < W; i++) begin
            cy[i+1] = gen_b[i] | (prop_b[i] & cy[i]);
        end
        sum_b = prop_b ^ cy[W-1:0];

        grp.gen  = 1'b0;
        grp.prop = 1'b1;
        for (int i = 0; i < W; i++) begin
            grp.gen  = gen_b[i] | (prop_b[i] & grp.gen);
            grp.prop = grp.prop & prop_b[i];
        end

        unique case (fsel)
            4'd0:    log_b = ~a;
            4'd1:    log_b = ~(a | b);
            4'd2:    log_b = ~a & b;
            4'd3:    log_b = '0;
            4'd4:    log_b = ~(a & b);
            4'd5:    log_b = ~b;
            4'd6:    log_b = a ^ b;
            4'd7:    log_b = a & ~b;
            4'd8:    log_b = ~a | b;
            4'd9:    log_b = ~(a ^ b);
            4'd10:   log_b = b;
            4'd11:   log_b = a & b;
            4'd12:   log_b = '1;
            4'd13:   log_b = a | ~b;
            4'd14:   log_b = a | b;
            default: log_b = a;
        endcase

        f = (mode == MODE_LOGIC) ? log_b : sum_b;
    end
endmodule

// File: rtl/tgen_lookahead.sv
module tgen_lookahead
    import tgen_pkg::*;
#(
    parameter int N = 3
) (
    input  slice_grp_t   grp [N],
    input  logic         c0,
    output logic [N-1:0] c_slice
);
    // Sum-of-products carry into every slice, no ripple through slices
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic term, path;
            term = c0;
            for (int k = 0; k < i; k++) begin
                term = term & grp[k].prop;
            end
            for (int j = 0; j < i; j++) begin
                path = grp[j].gen;
                for (int k = j + 1; k < i; k++) begin
                    path = path & grp[k].prop;
                end
                term = term | path;
            end
            c_slice[i] = term;
        end
    end
endmodule

// File: rtl/tgen_term.sv
module tgen_term
    import tgen_pkg::*;
#(
    parameter int IDX_W   = 10,
    parameter int GAIN_W  = 3,
    parameter int ALU_W   = 12,
    parameter int OUT_W   = 11,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic [ALU_W-1:0]  offset_i,
    input  logic [3:0]        fsel_i,
    input  logic              logic_mode_i,
    input  logic              carry_i,
    output logic [OUT_W-1:0]  term_o
);
    localparam int NSLICE = ALU_W / SLICE_W;

    typedef struct packed {
        logic [OUT_W-1:0] term;
    } tgen_state_t;

    logic [ALU_W-1:0]  opa;
    logic [ALU_W-1:0]  result;
    logic [NSLICE-1:0] c_slice;
    slice_grp_t        grp [NSLICE];
    alu_mode_e         mode;
    tgen_state_t       st_d, st_q;

    assign mode = alu_mode_e'(logic_mode_i);

    tgen_mult #(
        .IDX_W  (IDX_W),
        .GAIN_W (GAIN_W),
        .PROD_W (ALU_W)
    ) u_mult (
        .idx  (idx_i),
        .gain (gain_i),
        .prod (opa)
    );

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        tgen_slice #(.W(SLICE_W)) u_slice (
            .a    (opa[s*SLICE_W +: SLICE_W]),
            .b    (offset_i[s*SLICE_W +: SLICE_W]),
            .fsel (fsel_i),
            .mode (mode),
            .c_in (c_slice[s]),
            .f    (result[s*SLICE_W +: SLICE_W]),
            .grp  (grp[s])
        );
    end

    tgen_lookahead #(.N(NSLICE)) u_cla (
        .grp     (grp),
        .c0      (carry_i),
        .c_slice (c_slice)
    );

    always_comb begin
        st_d.term = result[OUT_W-1:0];
        if (st_d.term == '0) begin
            st_d.term = OUT_W'(1);
        end
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q.term <= OUT_W'(1);
            end else begin
                st_q <= st_d;
            end
        end
    end else begin : g_comb
        assign st_q = st_d;
    end

    assign term_o = st_q.term;
endmodule

// File: rtl/tgen_term_chk.sv
module tgen_term_chk #(
    parameter int IDX_W   = 10,
    parameter int GAIN_W  = 3,
    parameter int ALU_W   = 12,
    parameter int OUT_W   = 11,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  idx_i,
    input logic [GAIN_W-1:0] gain_i,
    input logic [ALU_W-1:0]  offset_i,
    input logic [3:0]        fsel_i,
    input logic              logic_mode_i,
    input logic              carry_i,
    input logic [OUT_W-1:0]  term_o
);
    function automatic logic [OUT_W-1:0] nz(input logic [ALU_W-1:0] v);
        logic [OUT_W-1:0] t;
        t = v[OUT_W-1:0];
        return (t == '0) ? OUT_W'(1) : t;
    endfunction

    function automatic logic [ALU_W-1:0] prod(input logic [IDX_W-1:0] b,
                                              input logic [GAIN_W-1:0] g);
        return ALU_W'(b * g);
    endfunction

    // R8
    p_never_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        term_o != '0);

    if (REG_OUT) begin : g_seq
        // R3
        p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!logic_mode_i && fsel_i == 4'd9 && !carry_i) |=>
            term_o == nz(prod($past(idx_i), $past(gain_i)) + $past(offset_i)));

        // R4
        p_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!logic_mode_i && fsel_i == 4'd6 && carry_i) |=>
            term_o == nz(prod($past(idx_i), $past(gain_i)) - $past(offset_i)));

        // R5
        p_xor_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (logic_mode_i && fsel_i == 4'd6) |=>
            term_o == nz(prod($past(idx_i), $past(gain_i)) ^ $past(offset_i)));

        // R2
        p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (logic_mode_i && fsel_i == 4'd15) |=>
            term_o == nz(prod($past(idx_i), $past(gain_i))));
    end
endmodule

bind tgen_term tgen_term_chk #(
    .IDX_W   (IDX_W),
    .GAIN_W  (GAIN_W),
    .ALU_W   (ALU_W),
    .OUT_W   (OUT_W),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .idx_i        (idx_i),
    .gain_i       (gain_i),
    .offset_i     (offset_i),
    .fsel_i       (fsel_i),
    .logic_mode_i (logic_mode_i),
    .carry_i      (carry_i),
    .term_o       (term_o)
);

// File: tb/sim_tgen_term.sv
`timescale 1ns/1ps
module sim_tgen_term;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  idx = '0;
    logic [2:0]  gain = '0;
    logic [11:0] offs = '0;
    logic [3:0]  fsel = '0;
    logic        lmode = 1'b0;
    logic        cin = 1'b0;
    logic [10:0] term;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tgen_term u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .idx_i        (idx),
        .gain_i       (gain),
        .offset_i     (offs),
        .fsel_i       (fsel),
        .logic_mode_i (lmode),
        .carry_i      (cin),
        .term_o       (term)
    );

    // Reference built from R2, R3, R5, R7, R8
    function automatic logic [10:0] ref_term(input logic [9:0] b, input logic [2:0] g,
                                             input logic [11:0] al, input logic [3:0] s,
                                             input logic m, input logic c);
        logic [11:0] a, x, y, f;
        logic [10:0] r;
        a = 12'((b * g) & 13'hFFF);
        if (!m) begin
            x = a | (s[0] ? al : 12'h0) | (s[1] ? ~al : 12'h0);
            y = a & ((s[2] ? ~al : 12'h0) | (s[3] ? al : 12'h0));
            f = x + y + 12'(c);
        end else begin
            case (s)
                4'd0:  f = ~a;
                4'd1:  f = ~(a | al);
                4'd2:  f = ~a & al;
                4'd3:  f = 12'h000;
                4'd4:  f = ~(a & al);
                4'd5:  f = ~al;
                4'd6:  f = a ^ al;
                4'd7:  f = a & ~al;
                4'd8:  f = ~a | al;
                4'd9:  f = ~(a ^ al);
                4'd10: f = al;
                4'd11: f = a & al;
                4'd12: f = 12'hFFF;
                4'd13: f = a | ~al;
                4'd14: f = a | al;
                default: f = a;
            endcase
        end
        r = f[10:0];
        return (r == 11'd0) ? 11'd1 : r;
    endfunction

    task automatic check(input logic [10:0] act, input logic [10:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge
    task automatic apply(input logic [9:0] b, input logic [2:0] g, input logic [11:0] al,
                         input logic [3:0] s, input logic m, input logic c);
        @(negedge clk);
        idx = b; gain = g; offs = al; fsel = s; lmode = m; cin = c;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(term, 11'd1, "R1 during reset");
        rst_n = 1'b1;
        #1;
        check(term, 11'd1, "R1 after release");
    endtask

    task automatic t_minus_one();
        for (int b = 1; b < 1024; b += 173) begin
            apply(10'(b), 3'd2, 12'd1, 4'd6, 1'b0, 1'b1);
            check(term, 11'(2 * b - 1), "R4 2b-1");
        end
        apply(10'd500, 3'd3, 12'd7, 4'd9, 1'b0, 1'b0);
        check(term, 11'd1507, "R3 add");
    endtask

    task automatic t_truncate();
        apply(10'd1023, 3'd7, 12'd0, 4'd15, 1'b1, 1'b0);
        check(term, 11'd1017, "R2 product truncation");
        apply(10'd1000, 3'd3, 12'd0, 4'd15, 1'b1, 1'b0);
        check(term, 11'd952, "R7 bit 11 dropped");
    endtask

    task automatic t_carry();
        apply(10'd255, 3'd1, 12'd1, 4'd9, 1'b0, 1'b0);
        check(term, 11'h100, "R9 carry across two slices");
        apply(10'd15, 3'd1, 12'd0, 4'd0, 1'b0, 1'b1);
        check(term, 11'h010, "R9 carry-in ripple");
    endtask

    task automatic t_zero();
        apply(10'd1023, 3'd2, 12'd1, 4'd9, 1'b0, 1'b1);
        check(term, 11'd1, "R8 low bits zero after 0x800");
        apply(10'd40, 3'd3, 12'd120, 4'd6, 1'b0, 1'b1);
        check(term, 11'd1, "R8 A-B equal");
        apply(10'd5, 3'd1, 12'd9, 4'd3, 1'b1, 1'b0);
        check(term, 11'd1, "R8 logic zero");
    endtask

    task automatic t_logic_carry();
        for (int s = 0; s < 16; s++) begin
            logic [10:0] a0;
            apply(10'd613, 3'd5, 12'hA5C, 4'(s), 1'b1, 1'b0);
            a0 = term;
            apply(10'd613, 3'd5, 12'hA5C, 4'(s), 1'b1, 1'b1);
            check(term, a0, "R6 carry ignored in logic mode");
        end
    endtask

    task automatic t_latency();
        apply(10'd100, 3'd1, 12'd0, 4'd15, 1'b1, 1'b0);
        @(negedge clk);
        idx = 10'd200;
        #2;
        check(term, 11'd100, "R10 holds before edge");
        @(negedge clk);
        check(term, 11'd200, "R10 updated after edge");
    endtask

    task automatic t_sweep();
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 16; s++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int n = 0; n < 4; n++) begin
                        logic [9:0]  b;
                        logic [2:0]  g;
                        logic [11:0] al;
                        b  = 10'($urandom);
                        g  = 3'($urandom);
                        al = 12'($urandom);
                        apply(b, g, al, 4'(s), 1'(m), 1'(c));
                        check(term, ref_term(b, g, al, 4'(s), 1'(m), 1'(c)),
                              m ? "R5 logic sweep" : "R3 arithmetic sweep");
                    end
                end
            end
        end
    endtask

    initial begin
        t_reset();
        t_minus_one();
        t_truncate();
        t_carry();
        t_zero();
        t_logic_carry();
        t_latency();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule